// File: doc/BRIEF.md
# Host Register Port with Burst Addressing

This block is the slave side of an asynchronous host bus with separate address and data strobes, used to reach the register bank of a telecom framer. The host raises the address strobe with chip select active, and the block latches a 9-bit register offset. Each data strobe after that moves one 16-bit word, and the read/write line picks the direction. If the address strobe is dropped before the data strobes, the access is a single access and every later data strobe reuses the latched offset. If the address strobe is held high across several data strobes, the access is a burst. In a burst, each completed data strobe advances the internal offset by one, and the burst stops when the address strobe falls.

The chip select, the address strobe and the data strobe are asynchronous to the local clock. Each passes through a flop synchroniser, and their edges are found in the local domain. The acknowledge output goes low once a strobed access is accepted and goes high again after the data strobe ends. Write data is committed when the data strobe is released.

The register bank holds these registers:
- a parameterised number of plain read/write control words, starting at offset 0;
- one mixed word, whose upper bits are writable and whose lower bits mirror hardware status;
- one read-only status word;
- one event word that clears itself when it is read.

The data bus is split into an input, an output and an output enable for the pad ring.

Top module: `hostbus_regif`

## Requirements
- R1: After reset, `dtack_n` is high, `data_oe_o` is low, and `cfg_o` and `mix_o` are zero.
- R2: A data strobe with `rw_i` low writes `data_i` to the latched offset when the strobe is released. Offsets 0 and 1 are read/write words, and `cfg_o[16*k +: 16]` shows word k.
- R3: While `cs_n` is low, an asserted `ds_n` pulls `dtack_n` low within a few clocks. `dtack_n` returns high within a few clocks after `ds_n` is released.
- R4: `data_oe_o` is high only during an acknowledged read (`rw_i` high). It stays low during writes and while idle.
- R5: If `as_i` stays high across several write strobes, the writes go to consecutive offsets starting at the latched one, for example 0, then 1, then 2.
- R6: Reads in a burst return consecutive offsets in the same way.
- R7: A fall of `as_i` ends the burst. Further data strobes without a new address phase stay at the last latched offset and do not increment.
- R8: Offset 3 reads `hw_status_i`, and writes to it change nothing.
- R9: For a write to offset 2, only the bits set in `MIX_MASK` (0xFF00) are stored and shown on `mix_o`. Reading offset 2 returns the stored upper bits merged with `hw_status_i` in the unmasked bits.
- R10: Offset 4 gathers pulses on `hw_evt_i`. A read returns the gathered bits and then clears them. An event active in the clearing clock survives the clear.
- R11: Strobes given while `cs_n` is high produce no acknowledge and no write.
- R12: An `as_i` rise while `cs_n` is high does not replace the latched offset.
- R13: Offsets 5 and above read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| as_i | input | 1 | Address strobe, active high; held high for a burst |
| ds_n | input | 1 | Data strobe, active low |
| rw_i | input | 1 | 1 = read, 0 = write |
| addr_i | input | 9 | Register offset, taken when the address strobe rises |
| data_i | input | 16 | Write data from the host |
| data_o | output | 16 | Read data toward the host |
| data_oe_o | output | 1 | Enable for the data pad drivers |
| dtack_n | output | 1 | Data acknowledge, active low |
| hw_status_i | input | 16 | Hardware status for the read-only word and the low half of the mixed word |
| hw_evt_i | input | 16 | Event set pulses for the self-clearing word |
| cfg_o | output | 32 | Contents of the read/write words, word k in bits 16k+15..16k |
| mix_o | output | 16 | Stored writable bits of the mixed word |

## Verification
The assertions assume the host obeys the bus handshake:
- `addr_i`, `rw_i` and `data_i` are stable from before their strobe asserts until it has been seen by the synchroniser.
- The data strobe is never re-asserted before the acknowledge has been released.
- The address strobe never moves while a data strobe is active.

The bench drives every input on the falling clock edge. Before each next step it waits for `dtack_n` to settle and then for two more clocks, so each access completes fully before the next one begins.

// File: rtl/hbr_pkg.sv
package hbr_pkg;
   typedef enum logic {
      ACC_WRITE = 1'b0,
      ACC_READ  = 1'b1
   } acc_dir_e;

   // offsets of the special words follow the plain read/write words
   function automatic int mix_offset(input int n_rw);
      return n_rw;
   endfunction

   function automatic int stat_offset(input int n_rw);
      return n_rw + 1;
   endfunction

   function automatic int evt_offset(input int n_rw);
      return n_rw + 2;
   endfunction
endpackage

// File: rtl/hbr_sync.sv
module hbr_sync #(
   parameter int          WIDTH     = 1,
   parameter int          STAGES    = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("hbr_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= {STAGES{RST_VAL}};
      end else begin
         chain_q[0] <= d_i;
         for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/hbr_strobe_ctl.sv
module hbr_strobe_ctl
   import hbr_pkg::*;
#(
   parameter int ADDR_W = 9,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_act,
   input  logic              as_act,
   input  logic              ds_act,
   input  logic              rw_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              ack_o,
   output logic              rd_act_o,
   output logic              wr_stb_o,
   output logic              rd_end_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W-1:0] wdata_o
);
   logic              ds_prev, as_prev, ack_q, burst_q;
   acc_dir_e          dir_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic              ds_on, ds_off, as_on, as_off, acc_end;

   assign ds_on   = ds_act & ~ds_prev & cs_act;
   assign ds_off  = ~ds_act & ds_prev;
   assign as_on   = as_act & ~as_prev;
   assign as_off  = ~as_act & as_prev;
   assign acc_end = ds_off & ack_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ds_prev <= 1'b0;
         as_prev <= 1'b0;
         ack_q   <= 1'b0;
         burst_q <= 1'b0;
         dir_q   <= ACC_WRITE;
         addr_q  <= '0;
         wdata_q <= '0;
      end else begin
         ds_prev <= ds_act;
         as_prev <= as_act;
         if (ds_on) begin
            ack_q   <= 1'b1;
            dir_q   <= acc_dir_e'(rw_i);
            wdata_q <= data_i;
         end else if (ds_off) begin
            ack_q <= 1'b0;
         end
         if (acc_end && burst_q) addr_q <= addr_q + 1'b1;
         if (as_on && cs_act) begin
            addr_q  <= addr_i;
            burst_q <= 1'b1;
         end else if (as_off) begin
            burst_q <= 1'b0;
         end
      end
   end

   assign ack_o    = ack_q;
   assign rd_act_o = ack_q & (dir_q == ACC_READ);
   assign wr_stb_o = acc_end & (dir_q == ACC_WRITE);
   assign rd_end_o = acc_end & (dir_q == ACC_READ);
   assign addr_o   = addr_q;
   assign wdata_o  = wdata_q;

   // R3: acknowledge drops right after the data strobe is released
   a_r3_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
      ds_off |=> !ack_q);
   // R11: no acknowledge can start while chip select is inactive
   a_r11_no_ack_unselected: assert property (@(posedge clk) disable iff (!rst_n)
      (!ack_q && !cs_act) |=> !ack_q);
   // R5: a finished access inside a burst advances the offset by one
   a_r5_burst_step: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_end && burst_q && !(as_on && cs_act)) |=>
         (addr_q == ADDR_W'($past(addr_q) + 1'b1)));
   // R7: falling address strobe closes the burst
   a_r7_burst_close: assert property (@(posedge clk) disable iff (!rst_n)
      as_off |=> !burst_q);
   // R12: outside a burst only a selected address phase moves the offset
   a_r12_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!burst_q && !(as_on && cs_act)) |=> $stable(addr_q));
endmodule

// File: rtl/hbr_regbank.sv
module hbr_regbank
   import hbr_pkg::*;
#(
   parameter int               ADDR_W   = 9,
   parameter int               DATA_W   = 16,
   parameter int               N_RW     = 2,
   parameter logic [DATA_W-1:0] MIX_MASK = 16'hFF00
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_stb_i,
   input  logic                     rd_end_i,
   input  logic [ADDR_W-1:0]        addr_i,
   input  logic [DATA_W-1:0]        wdata_i,
   input  logic [DATA_W-1:0]        hw_status_i,
   input  logic [DATA_W-1:0]        hw_evt_i,
   output logic [DATA_W-1:0]        rdata_o,
   output logic [N_RW*DATA_W-1:0]   cfg_o,
   output logic [DATA_W-1:0]        mix_o
);
   localparam logic [ADDR_W-1:0] OFF_MIX  = ADDR_W'(mix_offset(N_RW));
   localparam logic [ADDR_W-1:0] OFF_STAT = ADDR_W'(stat_offset(N_RW));
   localparam logic [ADDR_W-1:0] OFF_EVT  = ADDR_W'(evt_offset(N_RW));

   logic [N_RW-1:0][DATA_W-1:0] rw_q;
   logic [DATA_W-1:0]           mix_q, evt_q;
   logic                        evt_clr;

   assign evt_clr = rd_end_i & (addr_i == OFF_EVT);

   genvar gi;
   generate
      for (gi = 0; gi < N_RW; gi++) begin : g_rw
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                    rw_q[gi] <= '0;
            else if (wr_stb_i && addr_i == ADDR_W'(gi))    rw_q[gi] <= wdata_i;
         end
         assign cfg_o[gi*DATA_W +: DATA_W] = rw_q[gi];

         // R2: a word changes only on a write strobe to its own offset
         a_r2_rw_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_stb_i && addr_i == ADDR_W'(gi)) |=> $stable(rw_q[gi]));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mix_q <= '0;
         evt_q <= '0;
      end else begin
         if (wr_stb_i && addr_i == OFF_MIX) mix_q <= wdata_i & MIX_MASK;
         evt_q <= (evt_clr ? '0 : evt_q) | hw_evt_i;
      end
   end

   always_comb begin
      rdata_o = '0;
      for (int k = 0; k < N_RW; k++)
         if (addr_i == ADDR_W'(k)) rdata_o = rw_q[k];
      if (addr_i == OFF_MIX)  rdata_o = mix_q | (hw_status_i & ~MIX_MASK);
      if (addr_i == OFF_STAT) rdata_o = hw_status_i;
      if (addr_i == OFF_EVT)  rdata_o = evt_q;
   end

   assign mix_o = mix_q;

   // R10: an event arriving in the clearing clock is kept
   a_r10_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
      evt_clr |=> (evt_q == $past(hw_evt_i)));
   // R9: stored mixed word never holds bits outside the writable mask
   a_r9_mix_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb_i && addr_i == OFF_MIX) |=> ((mix_q & ~MIX_MASK) == '0));
endmodule

// File: rtl/hostbus_regif.sv
module hostbus_regif
   import hbr_pkg::*;
#(
   parameter int                ADDR_W      = 9,
   parameter int                DATA_W      = 16,
   parameter int                N_RW        = 2,
   parameter int                SYNC_STAGES = 2,
   parameter logic [DATA_W-1:0] MIX_MASK    = 16'hFF00
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cs_n,
   input  logic                   as_i,
   input  logic                   ds_n,
   input  logic                   rw_i,
   input  logic [ADDR_W-1:0]      addr_i,
   input  logic [DATA_W-1:0]      data_i,
   output logic [DATA_W-1:0]      data_o,
   output logic                   data_oe_o,
   output logic                   dtack_n,
   input  logic [DATA_W-1:0]      hw_status_i,
   input  logic [DATA_W-1:0]      hw_evt_i,
   output logic [N_RW*DATA_W-1:0] cfg_o,
   output logic [DATA_W-1:0]      mix_o
);
   localparam int N_OFFSETS = N_RW + 3;

   generate
      if (N_RW < 1) begin : g_bad_nrw
         $error("hostbus_regif: N_RW must be at least 1");
      end
      if ((1 << ADDR_W) < N_OFFSETS) begin : g_bad_addr
         $error("hostbus_regif: ADDR_W too small for the register map");
      end
   endgenerate

   logic [2:0]        strb_s;
   logic              ack, rd_act, wr_stb, rd_end;
   logic [ADDR_W-1:0] acc_addr;
   logic [DATA_W-1:0] wdata;

   // bit2 cs_n, bit1 as_i, bit0 ds_n; reset to the idle levels
   hbr_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b101)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({cs_n, as_i, ds_n}),
      .q_o   (strb_s)
   );

   hbr_strobe_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_act   (~strb_s[2]),
      .as_act   (strb_s[1]),
      .ds_act   (~strb_s[0]),
      .rw_i     (rw_i),
      .addr_i   (addr_i),
      .data_i   (data_i),
      .ack_o    (ack),
      .rd_act_o (rd_act),
      .wr_stb_o (wr_stb),
      .rd_end_o (rd_end),
      .addr_o   (acc_addr),
      .wdata_o  (wdata)
   );

   hbr_regbank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_RW(N_RW),
                 .MIX_MASK(MIX_MASK)) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_stb_i    (wr_stb),
      .rd_end_i    (rd_end),
      .addr_i      (acc_addr),
      .wdata_i     (wdata),
      .hw_status_i (hw_status_i),
      .hw_evt_i    (hw_evt_i),
      .rdata_o     (data_o),
      .cfg_o       (cfg_o),
      .mix_o       (mix_o)
   );

   assign dtack_n   = ~ack;
   assign data_oe_o = rd_act;

   // R4: pads drive only while an acknowledged access is in progress
   a_r4_oe_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
      data_oe_o |-> !dtack_n);
endmodule

// File: tb/tb_hostbus_regif.sv
module tb_hostbus_regif;
   localparam int CLK_PERIOD = 10;
   localparam int WD_CYCLES  = 100000;
   localparam int N_VEC      = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1, as_i = 1'b0, ds_n = 1'b1, rw_i = 1'b1;
   logic [8:0]  addr_i = '0;
   logic [15:0] data_i = '0, hw_status_i = 16'h5A3C, hw_evt_i = '0;
   logic [15:0] data_o, mix_o;
   logic        data_oe_o, dtack_n;
   logic [31:0] cfg_o;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hostbus_regif dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .as_i(as_i), .ds_n(ds_n),
      .rw_i(rw_i), .addr_i(addr_i), .data_i(data_i), .data_o(data_o),
      .data_oe_o(data_oe_o), .dtack_n(dtack_n), .hw_status_i(hw_status_i),
      .hw_evt_i(hw_evt_i), .cfg_o(cfg_o), .mix_o(mix_o)
   );

   // {write, offset, data, expected read}
   localparam logic [41:0] VEC [N_VEC] = '{
      {1'b1, 9'h000, 16'hA5A5, 16'h0000},
      {1'b1, 9'h001, 16'h1234, 16'h0000},
      {1'b0, 9'h000, 16'h0000, 16'hA5A5},
      {1'b0, 9'h001, 16'h0000, 16'h1234},
      {1'b1, 9'h002, 16'hFFFF, 16'h0000},
      {1'b0, 9'h002, 16'h0000, 16'hFF3C},
      {1'b1, 9'h003, 16'hDEAD, 16'h0000},
      {1'b0, 9'h003, 16'h0000, 16'h5A3C}
   };

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic addr_phase(input logic [8:0] a, input bit keep);
      @(negedge clk);
      cs_n = 1'b0; addr_i = a; as_i = 1'b1;
      repeat (4) @(negedge clk);
      if (!keep) begin
         as_i = 1'b0;
         repeat (4) @(negedge clk);
      end
   endtask

   task automatic access(input bit wr, input logic [15:0] wd, output logic [15:0] rd);
      int n;
      rd = '0;
      @(negedge clk);
      rw_i = ~wr; data_i = wd; ds_n = 1'b0;
      n = 0;
      while (dtack_n && n < 16) begin @(negedge clk); n++; end
      check(!dtack_n, "R3 ack asserted", {31'd0, dtack_n}, 32'd0);
      check(data_oe_o == !wr, "R4 oe during access", {31'd0, data_oe_o}, {31'd0, !wr});
      rd = data_o;
      ds_n = 1'b1;
      n = 0;
      while (!dtack_n && n < 16) begin @(negedge clk); n++; end
      check(dtack_n, "R3 ack released", {31'd0, dtack_n}, 32'd1);
      repeat (2) @(negedge clk);
      check(!data_oe_o, "R4 oe idle", {31'd0, data_oe_o}, 32'd0);
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      logic [15:0] q;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      // R1 reset state
      check(dtack_n == 1'b1, "R1 dtack idle", {31'd0, dtack_n}, 32'd1);
      check(data_oe_o == 1'b0, "R1 oe idle", {31'd0, data_oe_o}, 32'd0);
      check(cfg_o == '0, "R1 cfg zero", cfg_o, 32'd0);
      check(mix_o == '0, "R1 mix zero", {16'd0, mix_o}, 32'd0);

      // single accesses from the table: R2, R8, R9
      for (int i = 0; i < N_VEC; i++) begin
         addr_phase(VEC[i][40:32], 1'b0);
         access(VEC[i][41], VEC[i][31:16], q);
         if (!VEC[i][41])
            check(q == VEC[i][15:0], "R2/R8/R9 table read", {16'd0, q}, {16'd0, VEC[i][15:0]});
      end
      check(cfg_o == 32'h1234A5A5, "R2 cfg after writes", cfg_o, 32'h1234A5A5);
      check(mix_o == 16'hFF00, "R9 mix masked", {16'd0, mix_o}, 32'h0000FF00);
      check(cfg_o == 32'h1234A5A5, "R8 RO write no effect", cfg_o, 32'h1234A5A5);

      // R13 unmapped
      addr_phase(9'h007, 1'b0);
      access(1'b0, '0, q);
      check(q == 16'h0000, "R13 unmapped reads zero", {16'd0, q}, 32'd0);

      // R5 burst write 0,1,2
      addr_phase(9'h000, 1'b1);
      access(1'b1, 16'h1111, q);
      access(1'b1, 16'h2222, q);
      access(1'b1, 16'hABCD, q);
      as_i = 1'b0; repeat (4) @(negedge clk);
      check(cfg_o == 32'h22221111, "R5 burst write words", cfg_o, 32'h22221111);
      check(mix_o == 16'hAB00, "R5 burst third offset", {16'd0, mix_o}, 32'h0000AB00);

      // R6 burst read 0,1,2,3
      addr_phase(9'h000, 1'b1);
      access(1'b0, '0, q); check(q == 16'h1111, "R6 burst rd 0", {16'd0, q}, 32'h1111);
      access(1'b0, '0, q); check(q == 16'h2222, "R6 burst rd 1", {16'd0, q}, 32'h2222);
      access(1'b0, '0, q); check(q == 16'hAB3C, "R6 burst rd 2", {16'd0, q}, 32'hAB3C);
      access(1'b0, '0, q); check(q == 16'h5A3C, "R6 burst rd 3", {16'd0, q}, 32'h5A3C);
      as_i = 1'b0; repeat (4) @(negedge clk);

      // R7 no increment outside a burst
      addr_phase(9'h001, 1'b0);
      access(1'b1, 16'h7777, q);
      access(1'b1, 16'h8888, q);
      check(cfg_o == 32'h88881111, "R7 repeat stays on offset", cfg_o, 32'h88881111);
      check(mix_o == 16'hAB00, "R7 next offset untouched", {16'd0, mix_o}, 32'h0000AB00);

      // R11 strobes ignored without chip select
      @(negedge clk); cs_n = 1'b1; rw_i = 1'b0; data_i = 16'hEEEE; ds_n = 1'b0;
      for (int c = 0; c < 8; c++) begin
         @(negedge clk);
         if (!dtack_n) check(1'b0, "R11 ack while unselected", 32'd0, 32'd1);
      end
      ds_n = 1'b1; repeat (4) @(negedge clk);
      check(dtack_n == 1'b1, "R11 no ack", {31'd0, dtack_n}, 32'd1);
      check(cfg_o == 32'h88881111, "R11 no write", cfg_o, 32'h88881111);

      // R12 address phase unselected keeps offset
      as_i = 1'b0; addr_i = 9'h000; @(negedge clk); as_i = 1'b1;
      repeat (4) @(negedge clk); as_i = 1'b0; repeat (4) @(negedge clk);
      cs_n = 1'b0; repeat (4) @(negedge clk);
      access(1'b1, 16'h9999, q);
      check(cfg_o == 32'h99991111, "R12 latched offset kept", cfg_o, 32'h99991111);

      // R10 self-clearing event word
      @(negedge clk); hw_evt_i = 16'h0008; @(negedge clk); hw_evt_i = '0;
      repeat (2) @(negedge clk);
      addr_phase(9'h004, 1'b0);
      access(1'b0, '0, q); check(q == 16'h0008, "R10 event captured", {16'd0, q}, 32'h0008);
      access(1'b0, '0, q); check(q == 16'h0000, "R10 cleared by read", {16'd0, q}, 32'h0000);
      hw_evt_i = 16'h0100; repeat (2) @(negedge clk);
      access(1'b0, '0, q); check(q == 16'h0100, "R10 held event", {16'd0, q}, 32'h0100);
      access(1'b0, '0, q); check(q == 16'h0100, "R10 set beats clear", {16'd0, q}, 32'h0100);
      hw_evt_i = '0; repeat (2) @(negedge clk);
      access(1'b0, '0, q); check(q == 16'h0100, "R10 last value", {16'd0, q}, 32'h0100);
      access(1'b0, '0, q); check(q == 16'h0000, "R10 final clear", {16'd0, q}, 32'h0000);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule